// File: doc/BRIEF.md
# Nibble-Wide Character Display Bus Engine

This block turns byte-level requests from a host into cycles on a 4-bit character display bus. The bus has four data lines, a register-select line, a read/write line and an enable strobe. A request is one of three kinds. A full write sends a command or data byte as two enable pulses, upper nibble first. A single-nibble write sends only the upper nibble, which the power-up sequence needs while the display still expects an 8-bit bus. A status read always issues two enable pulses and returns the assembled status byte, whose top bit is the display's busy flag.

The enable timing is derived from a clock-frequency parameter and from three time parameters in nanoseconds: address/data setup before the strobe rises, strobe high time, and hold after it falls. The block owns the output-enable of the data lines and releases them whenever it reads. A write request may ask for busy polling. In that case, after the write the block keeps reading status until the busy bit is clear, and only then reports completion. A cycle-count limit ends the polling with an error flag. The display drops writes issued while it is busy, so a host that does not poll must pace its requests itself.

Top module: `lcd_nib_engine`

## Requirements
- R1: After reset, `lcd_e` is 0, `lcd_rw` is 0, `lcd_db_oe` is 1, `req_ready` is 1, and `done`, `busy_flag` and `timeout_err` are 0.
- R2: A full write (`req_kind` = 2'b00) produces exactly two enable pulses with `lcd_rw` = 0 and `lcd_rs` = `req_rs`. The first pulse carries `req_data[7:4]` on `lcd_db_o` and the second carries `req_data[3:0]`.
- R3: A single-nibble write (`req_kind` = 2'b01) produces exactly one enable pulse, carrying `req_data[7:4]`.
- R4: Each enable pulse stays high for exactly HIGH_CYC clock cycles. `lcd_rs`, `lcd_rw`, `lcd_db_o` and `lcd_db_oe` stay unchanged for at least SETUP_CYC cycles before `lcd_e` rises, while it is high, and for HOLD_CYC cycles after it falls.
- R5: A status read (`req_kind` = 2'b10 or 2'b11) produces two enable pulses with `lcd_rw` = 1 and `lcd_rs` = 0. `status` becomes {first nibble, second nibble}, and `busy_flag` equals `status[7]`.
- R6: The data lines are never driven while `lcd_rw` is 1, and read data is sampled in the last clock cycle that `lcd_e` is high.
- R7: After any transfer completes, `lcd_rw` is 0 and `lcd_db_oe` is 1.
- R8: A write with `req_poll` = 1 is followed by status-read pairs that repeat until bit 7 of the read status is 0. `done` is raised only after that. `req_poll` has no effect on a status read.
- R9: If polling goes on for POLL_LIMIT cycles while the display still reports busy, the block stops after the current read pair, raises `done` and sets `timeout_err`.
- R10: `req_ready` is 1 only while the block is idle, and no enable pulse occurs while it is 1. `done` is a single-cycle pulse. `timeout_err` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted on a clock edge where `req_ready` is 1 |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_kind | input | 2 | 00 full write, 01 single-nibble write, 1x status read |
| req_rs | input | 1 | Register select for writes: 0 command, 1 data |
| req_data | input | 8 | Byte to write |
| req_poll | input | 1 | Poll busy after a write before reporting completion |
| done | output | 1 | One-cycle pulse when a request completes |
| status | output | 8 | Last status byte read |
| busy_flag | output | 1 | Bit 7 of `status` |
| timeout_err | output | 1 | Last request ended on the poll limit |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_o | output | 4 | Data lines, output value |
| lcd_db_oe | output | 1 | Data line output enable |
| lcd_db_i | input | 4 | Data lines, input value |

## Verification
The assertions assume that `lcd_db_i` is steady from the rising strobe until the block samples it. The bench's display model meets this by driving the nibble as soon as the strobe rises and leaving it unchanged until the next rising strobe. They also assume requests arrive only through the handshake. The bench raises `req_valid` for a single cycle while `req_ready` is 1 and holds it low until `done`. For a polled write, the model reports busy for a preset number of status pairs, which gives the pulse counts checked by the bench.

// File: rtl/lcd_nib_pkg.sv
// Shared types and timing helpers for the nibble bus engine.
// Assumes times are given in nanoseconds and clock frequency in hertz.
package lcd_nib_pkg;

    typedef enum logic [1:0] {
        KIND_BYTE = 2'b00,
        KIND_NIB  = 2'b01,
        KIND_STAT = 2'b10,
        KIND_STB  = 2'b11
    } req_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } strobe_ph_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_READ
    } seq_st_t;

    // Rounds a time up to whole clock cycles, never below one cycle.
    function automatic int ns_to_cyc(input longint clk_hz, input longint t_ns);
        longint c;
        c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/lcd_nib_strobe.sv
// Enable strobe generator: one pulse of setup, high and hold phases per go.
// Assumes go is raised only when idle or in the last hold cycle (chaining).
module lcd_nib_strobe
    import lcd_nib_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 5,
    parameter int HOLD_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic e_o,
    output logic sample_o,
    output logic fin_o
);
    localparam int MAXA = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int MAXC = (MAXA > HOLD_CYC) ? MAXA : HOLD_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    strobe_ph_t    ph_q;
    logic [CW-1:0] cnt_q;
    logic          last_c;

    assign last_c = (cnt_q == '0);

    // Phase and cycle counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (go_i) begin
                        ph_q  <= PH_SETUP;
                        cnt_q <= CW'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (last_c) begin
                        ph_q  <= PH_HIGH;
                        cnt_q <= CW'(HIGH_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last_c) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= CW'(HOLD_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (last_c) begin
                        ph_q  <= go_i ? PH_SETUP : PH_IDLE;
                        cnt_q <= CW'(SETUP_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Phase decode to strobe and event outputs.
    always_comb begin
        e_o      = (ph_q == PH_HIGH);
        sample_o = (ph_q == PH_HIGH) && last_c;
        fin_o    = (ph_q == PH_HOLD) && last_c;
    end

endmodule

// File: rtl/lcd_nib_watch.sv
// Poll limit counter: counts cycles while run is high, flags once LIMIT is reached.
// Assumes clear is pulsed at the start of each request.
module lcd_nib_watch #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          exp_q;

    // Count poll cycles and latch expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (run_i && !exp_q) begin
            if (cnt_q == CW'(LIMIT - 1)) exp_q <= 1'b1;
            else                         cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = exp_q;

endmodule

// File: rtl/lcd_nib_seq.sv
// Transfer sequencer: orders write nibbles, status read pairs and busy polling.
// Owns the bus control registers; changes them only on go edges or on completion.
module lcd_nib_seq
    import lcd_nib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    input  logic       req_rs_i,
    input  logic [7:0] req_data_i,
    input  logic       req_poll_i,
    input  logic       fin_i,
    input  logic       sample_i,
    input  logic       expired_i,
    input  logic [3:0] db_i,
    output logic       go_o,
    output logic       watch_clear_o,
    output logic       watch_run_o,
    output logic       ready_o,
    output logic       done_o,
    output logic [7:0] status_o,
    output logic       err_o,
    output logic       rs_o,
    output logic       rw_o,
    output logic [3:0] db_o,
    output logic       oe_o
);
    seq_st_t    st_q;
    req_kind_t  kind_c;
    logic [7:0] data_q;
    logic       poll_q;
    logic       second_q;
    logic [3:0] hi_q;
    logic [7:0] status_q;
    logic       done_q;
    logic       err_q;
    logic       rs_q;
    logic       rw_q;
    logic [3:0] db_q;
    logic       oe_q;
    logic       accept_c;
    logic       keep_poll_c;

    assign kind_c      = req_kind_t'(req_kind_i);
    assign accept_c    = (st_q == SQ_IDLE) && req_valid_i;
    assign keep_poll_c = poll_q && hi_q[3] && !expired_i;

    // Strobe launch: on acceptance, and chained at the end of a pulse when more follow.
    always_comb begin
        go_o = 1'b0;
        if (accept_c) begin
            go_o = 1'b1;
        end else if (fin_i) begin
            case (st_q)
                SQ_WRITE: go_o = !second_q || poll_q;
                SQ_READ:  go_o = !second_q || keep_poll_c;
                default:  go_o = 1'b0;
            endcase
        end
    end

    // Request state, bus control and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            data_q   <= '0;
            poll_q   <= 1'b0;
            second_q <= 1'b0;
            hi_q     <= '0;
            status_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rs_q     <= 1'b0;
            rw_q     <= 1'b0;
            db_q     <= '0;
            oe_q     <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (accept_c) begin
                data_q <= req_data_i;
                err_q  <= 1'b0;
                case (kind_c)
                    KIND_BYTE, KIND_NIB: begin
                        st_q     <= SQ_WRITE;
                        second_q <= (kind_c == KIND_NIB);
                        poll_q   <= req_poll_i;
                        rs_q     <= req_rs_i;
                        rw_q     <= 1'b0;
                        oe_q     <= 1'b1;
                        db_q     <= req_data_i[7:4];
                    end
                    default: begin
                        st_q     <= SQ_READ;
                        second_q <= 1'b0;
                        poll_q   <= 1'b0;
                        rs_q     <= 1'b0;
                        oe_q     <= 1'b0;
                        rw_q     <= 1'b1;
                    end
                endcase
            end else begin
                if (sample_i && (st_q == SQ_READ)) begin
                    if (!second_q) hi_q     <= db_i;
                    else           status_q <= {hi_q, db_i};
                end
                if (fin_i) begin
                    case (st_q)
                        SQ_WRITE: begin
                            if (!second_q) begin
                                second_q <= 1'b1;
                                db_q     <= data_q[3:0];
                            end else if (poll_q) begin
                                st_q     <= SQ_READ;
                                second_q <= 1'b0;
                                rs_q     <= 1'b0;
                                oe_q     <= 1'b0;
                                rw_q     <= 1'b1;
                            end else begin
                                st_q   <= SQ_IDLE;
                                done_q <= 1'b1;
                            end
                        end
                        SQ_READ: begin
                            if (!second_q) begin
                                second_q <= 1'b1;
                            end else if (keep_poll_c) begin
                                second_q <= 1'b0;
                            end else begin
                                err_q  <= poll_q && hi_q[3];
                                st_q   <= SQ_IDLE;
                                done_q <= 1'b1;
                                rw_q   <= 1'b0;
                                oe_q   <= 1'b1;
                            end
                        end
                        default: st_q <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

    // Output mapping.
    always_comb begin
        watch_clear_o = accept_c;
        watch_run_o   = (st_q == SQ_READ) && poll_q;
        ready_o       = (st_q == SQ_IDLE);
        done_o        = done_q;
        status_o      = status_q;
        err_o         = err_q;
        rs_o          = rs_q;
        rw_o          = rw_q;
        db_o          = db_q;
        oe_o          = oe_q;
    end

endmodule

// File: rtl/lcd_nib_engine.sv
// Top of the nibble bus engine: derives strobe timing from the clock rate and
// joins sequencer, strobe generator and poll limit counter.
// Assumes lcd_db_i is steady while lcd_e is high during reads.
module lcd_nib_engine
    import lcd_nib_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int T_SETUP_NS = 40,
    parameter int T_HIGH_NS  = 100,
    parameter int T_HOLD_NS  = 20,
    parameter int POLL_LIMIT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_kind,
    input  logic       req_rs,
    input  logic [7:0] req_data,
    input  logic       req_poll,
    output logic       done,
    output logic [7:0] status,
    output logic       busy_flag,
    output logic       timeout_err,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] lcd_db_o,
    output logic       lcd_db_oe,
    input  logic [3:0] lcd_db_i
);
    localparam int SETUP_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(T_SETUP_NS));
    localparam int HIGH_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(T_HIGH_NS));
    localparam int HOLD_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(T_HOLD_NS));

    logic go, sample, fin, expired, w_clear, w_run;

    lcd_nib_strobe #(
        .SETUP_CYC(SETUP_CYC),
        .HIGH_CYC (HIGH_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .e_o     (lcd_e),
        .sample_o(sample),
        .fin_o   (fin)
    );

    lcd_nib_watch #(.LIMIT(POLL_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (w_clear),
        .run_i    (w_run),
        .expired_o(expired)
    );

    lcd_nib_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_kind_i   (req_kind),
        .req_rs_i     (req_rs),
        .req_data_i   (req_data),
        .req_poll_i   (req_poll),
        .fin_i        (fin),
        .sample_i     (sample),
        .expired_i    (expired),
        .db_i         (lcd_db_i),
        .go_o         (go),
        .watch_clear_o(w_clear),
        .watch_run_o  (w_run),
        .ready_o      (req_ready),
        .done_o       (done),
        .status_o     (status),
        .err_o        (timeout_err),
        .rs_o         (lcd_rs),
        .rw_o         (lcd_rw),
        .db_o         (lcd_db_o),
        .oe_o         (lcd_db_oe)
    );

    assign busy_flag = status[7];

endmodule

// File: rtl/lcd_nib_engine_chk.sv
// Port-level property checker for the nibble bus engine, attached by bind.
module lcd_nib_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       timeout_err,
    input logic [7:0] status,
    input logic       busy_flag,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [3:0] lcd_db_o,
    input logic       lcd_db_oe
);
    // R6: bus released whenever reading
    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> !lcd_db_oe);

    // R4: controls settled before the strobe rises
    p_setup_before_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_o) && $stable(lcd_db_oe)));

    // R4: controls held while the strobe is high
    p_stable_while_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_o)));

    // R4: controls held across the falling edge
    p_hold_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_o)));

    // R10: no strobe while idle
    p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !req_ready);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: error only appears together with completion
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);

    // R7: bus back to write drive at completion
    p_release_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!lcd_rw && lcd_db_oe));

    // R5: busy flag mirrors status bit 7
    always_comb begin
        if (rst_n) begin
            a_busy_bit_r5: assert (busy_flag == status[7]);
        end
    end

endmodule

bind lcd_nib_engine lcd_nib_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .timeout_err(timeout_err),
    .status     (status),
    .busy_flag  (busy_flag),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_o   (lcd_db_o),
    .lcd_db_oe  (lcd_db_oe)
);

// File: tb/lcd_nib_engine_test.sv
// Self-checking bench with a behavioural display responder.
module lcd_nib_engine_test;

    localparam int SETUP = 2;
    localparam int HIGHC = 5;
    localparam int LIMIT = 200;
    localparam logic [6:0] ADDR = 7'h2A;

    typedef struct packed {
        logic [1:0] kind;
        logic       rs;
        logic [7:0] data;
        logic       poll;
        logic [7:0] busy_n;
        logic [1:0] exp_wr;
        logic [7:0] exp_rd;
        logic [7:0] exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 8'h28, 1'b0, 8'd0, 2'd2, 8'd0, 8'h00},  // R2 command byte
        '{2'b00, 1'b1, 8'hC5, 1'b0, 8'd0, 2'd2, 8'd0, 8'h00},  // R2 data byte
        '{2'b01, 1'b0, 8'h30, 1'b0, 8'd0, 2'd1, 8'd0, 8'h00},  // R3 nibble
        '{2'b10, 1'b0, 8'h00, 1'b0, 8'd0, 2'd0, 8'd2, 8'h2A},  // R5 idle status
        '{2'b11, 1'b0, 8'h00, 1'b0, 8'd3, 2'd0, 8'd2, 8'hAA},  // R5 busy status
        '{2'b00, 1'b1, 8'h7E, 1'b1, 8'd0, 2'd2, 8'd2, 8'h2A},  // R8 poll, ready at once
        '{2'b00, 1'b0, 8'h01, 1'b1, 8'd2, 2'd2, 8'd6, 8'h2A},  // R8 poll, two busy
        '{2'b01, 1'b0, 8'h20, 1'b1, 8'd1, 2'd1, 8'd4, 8'h2A},  // R8 nibble then poll
        '{2'b10, 1'b0, 8'h00, 1'b1, 8'd2, 2'd0, 8'd2, 8'hAA}   // R8 poll ignored on read
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'b00;
    logic       req_rs = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       req_poll = 1'b0;
    logic       done;
    logic [7:0] status;
    logic       busy_flag;
    logic       timeout_err;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [3:0] lcd_db_o;
    logic [3:0] lcd_db_i = 4'h0;

    always #10 clk = ~clk;

    lcd_nib_engine #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_rs(req_rs), .req_data(req_data), .req_poll(req_poll),
        .done(done), .status(status), .busy_flag(busy_flag), .timeout_err(timeout_err),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db_o(lcd_db_o),
        .lcd_db_oe(lcd_db_oe), .lcd_db_i(lcd_db_i)
    );

    int checks = 0;
    int fails = 0;
    int busy_left = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic rd_phase = 1'b0;
    logic [3:0] wr_nib [4];
    logic       wr_rs  [4];
    int setup_viol = 0, width_viol = 0, drive_viol = 0, hold_viol = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Display responder: capture written nibbles, answer status reads.
    always @(negedge lcd_e) begin
        if (!lcd_rw) begin
            if (wr_cnt < 4) begin
                wr_nib[wr_cnt] = lcd_db_o;
                wr_rs[wr_cnt]  = lcd_rs;
            end
            wr_cnt++;
        end else begin
            rd_cnt++;
            if (rd_phase && busy_left > 0) busy_left--;
            rd_phase = ~rd_phase;
        end
    end

    always @(posedge lcd_e) begin
        if (lcd_rw) begin
            if (!rd_phase) lcd_db_i = {(busy_left > 0), ADDR[6:4]};
            else           lcd_db_i = ADDR[3:0];
        end
    end

    // Bus timing monitor for R4 and R6, sampled away from the clock edge.
    int   stable_n = 0;
    int   high_n = 0;
    logic prev_e = 1'b0;
    logic [6:0] prev_ctl = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [6:0] ctl;
            ctl = {lcd_rs, lcd_rw, lcd_db_o, lcd_db_oe};
            if (ctl != prev_ctl) begin
                if (lcd_e || prev_e) hold_viol++;
                stable_n = 1;
            end else begin
                stable_n++;
            end
            if (lcd_e && !prev_e && stable_n < SETUP + 1) setup_viol++;
            if (lcd_e) high_n++;
            if (!lcd_e && prev_e) begin
                if (high_n != HIGHC) width_viol++;
                high_n = 0;
            end
            if (lcd_rw && lcd_db_oe) drive_viol++;
            prev_ctl = ctl;
            prev_e   = lcd_e;
        end
    end

    // Issue one request and wait for completion; watchdog counts as a failure.
    task automatic run_req(input logic [1:0] k, input logic rs, input logic [7:0] d,
                           input logic p, output bit ok);
        int n;
        wr_cnt = 0;
        rd_cnt = 0;
        rd_phase = 1'b0;
        @(negedge clk);
        req_kind = k; req_rs = rs; req_data = d; req_poll = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        ok = done;
        if (!ok) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual no done expected done");
        end
    endtask

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 e",     {31'd0, lcd_e},      32'd0);
        check("R1 rw",    {31'd0, lcd_rw},     32'd0);
        check("R1 oe",    {31'd0, lcd_db_oe},  32'd1);
        check("R1 ready", {31'd0, req_ready},  32'd1);
        check("R1 flags", {29'd0, done, busy_flag, timeout_err}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            busy_left = int'(v.busy_n);
            run_req(v.kind, v.rs, v.data, v.poll, ok);
            if (ok) begin
                check("R2/R3 nibble count", wr_cnt, {30'd0, v.exp_wr});
                if (v.exp_wr >= 1) begin
                    check("R2 first nibble", {28'd0, wr_nib[0]}, {28'd0, v.data[7:4]});
                    check("R2 rs",           {31'd0, wr_rs[0]},  {31'd0, v.rs});
                end
                if (v.exp_wr == 2)
                    check("R2 second nibble", {28'd0, wr_nib[1]}, {28'd0, v.data[3:0]});
                check("R8 read pulses", rd_cnt, {24'd0, v.exp_rd});
                if (v.exp_rd != 0) begin
                    check("R5 status", {24'd0, status},    {24'd0, v.exp_st});
                    check("R5 busy",   {31'd0, busy_flag}, {31'd0, v.exp_st[7]});
                end
                check("R7 rw/oe after", {30'd0, lcd_rw, lcd_db_oe}, 32'd1);
                check("R9 no error",    {31'd0, timeout_err}, 32'd0);
                @(negedge clk);
                check("R10 done pulse", {31'd0, done}, 32'd0);
            end
        end

        // R9 poll limit while the display stays busy
        busy_left = 100000;
        run_req(2'b00, 1'b0, 8'h0C, 1'b1, ok);
        if (ok) begin
            check("R9 error set",      {31'd0, timeout_err}, 32'd1);
            check("R9 busy reported",  {31'd0, busy_flag},   32'd1);
            check("R9 even read pulses", {31'd0, rd_cnt[0]}, 32'd0);
            check("R9 bounded reads",  {31'd0, (rd_cnt <= 2 * (LIMIT / 16 + 2))}, 32'd1);
        end

        // R10 error clears on the next accepted request
        busy_left = 0;
        run_req(2'b01, 1'b1, 8'h90, 1'b0, ok);
        if (ok) begin
            check("R10 error cleared", {31'd0, timeout_err}, 32'd0);
            check("R3 nibble only",    wr_cnt, 32'd1);
            check("R3 rs data",        {31'd0, wr_rs[0]}, 32'd1);
        end

        // R4 and R6 bus timing accumulated over the whole run
        check("R4 setup",     setup_viol, 32'd0);
        check("R4 high width", width_viol, 32'd0);
        check("R4 hold",      hold_viol,  32'd0);
        check("R6 no drive on read", drive_viol, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule